// File: doc/BRIEF.md
# Signature-Based Datapath Self-Test Controller

This block runs a built-in test of an external arithmetic unit. A pseudorandom generator supplies a pair of operands for each pattern. For every pattern the controller steps through a fixed set of function codes, one per clock, and folds each returned result into a signature compactor. After a fixed number of patterns the signature gives a compact fingerprint of the datapath's behaviour.

The controller has two modes, chosen when a run starts. A calibration run goes through the full pattern count and then captures the final signature as the reference. No other path can change the reference. A test run replays the same sequence from the same start state and compares the compactor with the reference at the end of every pattern. A match counts as a pass only when it falls on the last pattern. A match at any earlier pattern means the fault has hidden itself, and the run stops at once and reports failure. A run that never matches also ends as a failure, at the last pattern, so no run can hang.

Top module: `selftest_ctrl`

## Requirements
- R1: After reset, `busy_o`, `pass_o` and `fail_o` are low. `pass_o` and `fail_o` are never high together, and both are low whenever `busy_o` is high.
- R2: The operand generator is a 32-bit shift-left register with conditional feedback: next = {s[30:0],0} XOR (s[31] ? 32'h04C11DB7 : 0). It is seeded with 32'hACE15EED at reset and at every accepted start. `alu_a_o` carries bits 31:16 and `alu_b_o` carries bits 15:0. The register advances once per pattern.
- R3: In each pattern `alu_op_o` counts 0,1,...,NUM_OPS-1, one code per busy cycle, and the operands stay constant within the pattern.
- R4: In every busy cycle the 16-bit compactor takes in `alu_res_i` as m' = ({m[14:0],0} XOR (m[15] ? 16'h1021 : 0)) XOR alu_res_i. It is cleared to zero at reset and at every accepted start.
- R5: A calibration run keeps `busy_o` high for exactly NUM_PAT*NUM_OPS cycles. It then raises `pass_o` and stores the final signature as the reference.
- R6: The reference changes only at the end of a calibration run. Test runs, including failing ones, leave it untouched.
- R7: A test run whose final signature equals the reference stays busy for exactly NUM_PAT*NUM_OPS cycles and then raises `pass_o`.
- R8: A test run whose signature differs from the reference at the last pattern stays busy for the full length and then raises `fail_o`.
- R9: If the signature equals the reference at the end of pattern k < NUM_PAT-1 (patterns counted from 0) in a test run, the run ends after (k+1)*NUM_OPS busy cycles with `fail_o` high.
- R10: A test start with no reference captured since reset does not run. It raises `fail_o` one cycle later.
- R11: `start_i` has no effect while `busy_o` is high. This covers the mode input and any restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (sampled when idle) |
| cal_mode_i | input | 1 | 1 = calibration run, 0 = test run; latched at start |
| alu_a_o | output | DATA_W | First operand to the unit under test |
| alu_b_o | output | DATA_W | Second operand to the unit under test |
| alu_op_o | output | OP_W | Function code to the unit under test |
| alu_res_i | input | DATA_W | Combinational result from the unit under test |
| busy_o | output | 1 | Run in progress |
| pass_o | output | 1 | Last run ended good; held until the next start |
| fail_o | output | 1 | Last run ended bad; held until the next start |

## Verification
The bench models the unit under test with four functions and runs it in four forms. A fault-free unit shows that calibration and test produce the same signature and that the pass lands at exactly full length. A unit with one flipped result bit on one function code separates a mismatch at the last pattern from a pass. A unit that forges one result so the compactor reaches the reference at pattern 100 shows that an early match is treated as failure and not as success. A good test after the faulty ones shows that the reference survived them. Operands and function codes are compared every cycle against an independent model of the generator.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1
  } stc_state_e;

  localparam logic [31:0] STC_LFSR_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] STC_LFSR_SEED = 32'hACE1_5EED;
  localparam logic [15:0] STC_MISR_POLY = 16'h1021;
endpackage

// File: rtl/stc_lfsr.sv
module stc_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] POLY = '1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (init_i) q <= SEED;
    else if (adv_i)  q <= {q[W-2:0], 1'b0} ^ (q[W-1] ? POLY : '0);
  end

  assign state_o = q;
endmodule

// File: rtl/stc_misr.sv
module stc_misr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] q;

  assign next_o = ({q[W-2:0], 1'b0} ^ (q[W-1] ? POLY : '0)) ^ data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (clr_i) q <= '0;
    else if (en_i)  q <= next_o;
  end
endmodule

// File: rtl/stc_golden.sv
module stc_golden #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sig_o,
  output logic         vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_o <= '0;
      vld_o <= 1'b0;
    end else if (load_i) begin
      sig_o <= data_i;
      vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/selftest_ctrl.sv
module selftest_ctrl
  import stc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_PAT = 1024,
  parameter int NUM_OPS = 4,
  localparam int OP_W   = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cal_mode_i,
  output logic [DATA_W-1:0] alu_a_o,
  output logic [DATA_W-1:0] alu_b_o,
  output logic [OP_W-1:0]   alu_op_o,
  input  logic [DATA_W-1:0] alu_res_i,
  output logic              busy_o,
  output logic              pass_o,
  output logic              fail_o
);
  localparam int LFSR_W = 2 * DATA_W;
  localparam int PAT_W  = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;
  localparam logic [PAT_W-1:0] PAT_LAST = PAT_W'(NUM_PAT - 1);
  localparam logic [OP_W-1:0]  OP_LAST  = OP_W'(NUM_OPS - 1);

  stc_state_e       state_q;
  logic             cal_q;
  logic [PAT_W-1:0] pat_q;
  logic [OP_W-1:0]  op_q;
  logic             pass_q, fail_q;

  logic              run, accept, op_last, pat_last, sig_match, gold_load;
  logic [LFSR_W-1:0] lfsr_s;
  logic [DATA_W-1:0] misr_nx, gold_sig;
  logic              gold_vld;

  assign run      = (state_q == ST_RUN);
  assign accept   = start_i && !run;
  assign op_last  = (op_q == OP_LAST);
  assign pat_last = (pat_q == PAT_LAST);
  assign sig_match = (misr_nx == gold_sig);
  assign gold_load = run && cal_q && op_last && pat_last;

  stc_lfsr #(.W(LFSR_W), .POLY(LFSR_W'(STC_LFSR_POLY)), .SEED(LFSR_W'(STC_LFSR_SEED))) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (accept),
    .adv_i   (run && op_last),
    .state_o (lfsr_s)
  );

  stc_misr #(.W(DATA_W), .POLY(DATA_W'(STC_MISR_POLY))) u_misr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (run),
    .data_i (alu_res_i),
    .next_o (misr_nx)
  );

  stc_golden #(.W(DATA_W)) u_gold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gold_load),
    .data_i (misr_nx),
    .sig_o  (gold_sig),
    .vld_o  (gold_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cal_q   <= 1'b0;
      pat_q   <= '0;
      op_q    <= '0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else if (accept) begin
      cal_q  <= cal_mode_i;
      pat_q  <= '0;
      op_q   <= '0;
      pass_q <= 1'b0;
      if (!cal_mode_i && !gold_vld) begin
        fail_q <= 1'b1;   // no reference to compare against
      end else begin
        fail_q  <= 1'b0;
        state_q <= ST_RUN;
      end
    end else if (run) begin
      op_q <= op_last ? '0 : op_q + 1'b1;
      if (op_last) begin
        pat_q <= pat_q + 1'b1;
        if (cal_q) begin
          if (pat_last) begin
            pass_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end else if (pat_last) begin
          pass_q  <= sig_match;
          fail_q  <= !sig_match;
          state_q <= ST_IDLE;
        end else if (sig_match) begin
          fail_q  <= 1'b1;   // match before the expected count is untrusted
          state_q <= ST_IDLE;
        end
      end
    end
  end

  assign alu_a_o  = lfsr_s[LFSR_W-1:DATA_W];
  assign alu_b_o  = lfsr_s[DATA_W-1:0];
  assign alu_op_o = op_q;
  assign busy_o   = run;
  assign pass_o   = pass_q;
  assign fail_o   = fail_q;
endmodule

// File: rtl/stc_chk.sv
module stc_chk #(
  parameter int DATA_W  = 16,
  parameter int NUM_PAT = 1024,
  parameter int NUM_OPS = 4,
  localparam int OP_W   = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] alu_a_o,
  input logic [DATA_W-1:0] alu_b_o,
  input logic [OP_W-1:0]   alu_op_o,
  input logic              busy_o,
  input logic              pass_o,
  input logic              fail_o
);
  localparam int RUN_LEN = NUM_PAT * NUM_OPS;
  localparam int CNT_W   = $clog2(RUN_LEN + 1) + 1;
  localparam logic [2*DATA_W-1:0] SEED = (2*DATA_W)'(stc_pkg::STC_LFSR_SEED);

  logic [CNT_W-1:0] busy_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  // R1
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o) && (busy_o -> (!pass_o && !fail_o)));

  // R2
  seed_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (alu_op_o == '0) && ({alu_a_o, alu_b_o} == SEED));

  // R3
  op_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && alu_op_o != '0) |-> (alu_op_o == OP_W'($past(alu_op_o) + 1'b1)));

  // R3
  opnd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && alu_op_o != '0) |-> ($stable(alu_a_o) && $stable(alu_b_o)));

  // R7
  pass_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && pass_o) |-> (busy_cnt == CNT_W'(RUN_LEN)));

  // R9
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt < CNT_W'(RUN_LEN)));
endmodule

bind selftest_ctrl stc_chk #(
  .DATA_W  (DATA_W),
  .NUM_PAT (NUM_PAT),
  .NUM_OPS (NUM_OPS)
) u_stc_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .alu_a_o  (alu_a_o),
  .alu_b_o  (alu_b_o),
  .alu_op_o (alu_op_o),
  .busy_o   (busy_o),
  .pass_o   (pass_o),
  .fail_o   (fail_o)
);

// File: tb/tb_selftest_ctrl.sv
module tb_selftest_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 16;
  localparam int NUM_PAT = 1024;
  localparam int NUM_OPS = 4;
  localparam int RUN_LEN = NUM_PAT * NUM_OPS;
  localparam int WDOG    = 150000;
  localparam logic [31:0] G_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] G_SEED = 32'hACE1_5EED;
  localparam logic [15:0] C_POLY = 16'h1021;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        cal_mode_i = 1'b0;
  logic [15:0] alu_a_o, alu_b_o, alu_res_i;
  logic [1:0]  alu_op_o;
  logic        busy_o, pass_o, fail_o;

  selftest_ctrl #(.DATA_W(DATA_W), .NUM_PAT(NUM_PAT), .NUM_OPS(NUM_OPS)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cal_mode_i(cal_mode_i),
    .alu_a_o(alu_a_o), .alu_b_o(alu_b_o), .alu_op_o(alu_op_o), .alu_res_i(alu_res_i),
    .busy_o(busy_o), .pass_o(pass_o), .fail_o(fail_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_gen;
  logic [15:0] m_sig, m_ref;
  int m_op, m_pat, opnd_err, fault_sel, craft_pat;

  initial alu_res_i = '0;

  function automatic logic [31:0] gen_nx(input logic [31:0] s);
    return {s[30:0], 1'b0} ^ (s[31] ? G_POLY : 32'h0);
  endfunction

  function automatic logic [15:0] sig_sh(input logic [15:0] m);
    return {m[14:0], 1'b0} ^ (m[15] ? C_POLY : 16'h0);
  endfunction

  function automatic logic [15:0] unit_fn(input logic [15:0] a, b, input int op);
    case (op)
      0: return a + b;
      1: return a ^ b;
      2: return a & b;
      default: return a - b;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Reference model of the unit under test and of the operand/signature sequence
  always @(negedge clk_i) begin
    if (rst_ni && busy_o) begin
      logic [15:0] r;
      if ({alu_a_o, alu_b_o} !== m_gen || int'(alu_op_o) != m_op) opnd_err++;
      r = unit_fn(m_gen[31:16], m_gen[15:0], m_op);
      if (fault_sel == 1 && m_op == 1) r = r ^ 16'h0001;
      if (fault_sel == 2 && m_pat == craft_pat && m_op == NUM_OPS-1) r = sig_sh(m_sig) ^ m_ref;
      alu_res_i = r;
      m_sig = sig_sh(m_sig) ^ r;
      if (m_op == NUM_OPS-1) begin
        m_op = 0;
        m_gen = gen_nx(m_gen);
        m_pat++;
      end else begin
        m_op++;
      end
    end
  end

  task automatic start_run(input bit cal);
    @(negedge clk_i);
    start_i = 1'b1;
    cal_mode_i = cal;
    m_gen = G_SEED; m_sig = '0; m_op = 0; m_pat = 0; opnd_err = 0;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(inout int len);
    while (busy_o) begin
      len++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    check(!busy_o && !pass_o && !fail_o, "R1", "status after reset",
          {busy_o, pass_o, fail_o}, 0);
  endtask

  task automatic t_no_ref();
    start_run(1'b0);
    check(!busy_o, "R10", "busy without reference", busy_o, 0);
    check(fail_o && !pass_o, "R10", "fail without reference", {fail_o, pass_o}, 2);
  endtask

  task automatic t_calibrate();
    int len = 0;
    fault_sel = 0;
    start_run(1'b1);
    wait_done(len);
    check(len == RUN_LEN, "R5", "calibration length", len, RUN_LEN);
    check(pass_o && !fail_o, "R5", "calibration status", {pass_o, fail_o}, 2);
    check(opnd_err == 0, "R2", "operand sequence errors", opnd_err, 0);
    check(opnd_err == 0, "R3", "op code sequence errors", opnd_err, 0);
    m_ref = m_sig;
  endtask

  task automatic t_test_good(input string req);
    int len = 0;
    fault_sel = 0;
    start_run(1'b0);
    wait_done(len);
    check(len == RUN_LEN, req, "good test length", len, RUN_LEN);
    check(pass_o && !fail_o, req, "good test status", {pass_o, fail_o}, 2);
    check(m_sig == m_ref, "R4", "model signature vs reference", m_sig, m_ref);
  endtask

  task automatic t_test_fault();
    int len = 0;
    fault_sel = 1;
    start_run(1'b0);
    wait_done(len);
    check(len == RUN_LEN, "R8", "faulty test length", len, RUN_LEN);
    check(fail_o && !pass_o, "R8", "faulty test status", {fail_o, pass_o}, 2);
    fault_sel = 0;
  endtask

  task automatic t_premature();
    int len = 0;
    fault_sel = 2;
    craft_pat = 100;
    start_run(1'b0);
    wait_done(len);
    check(len == (craft_pat + 1) * NUM_OPS, "R9", "early match run length", len, (craft_pat + 1) * NUM_OPS);
    check(fail_o && !pass_o, "R9", "early match status", {fail_o, pass_o}, 2);
    check(opnd_err == 0, "R4", "operands before early stop", opnd_err, 0);
    fault_sel = 0;
  endtask

  task automatic t_busy_start();
    int len = 0;
    fault_sel = 0;
    start_run(1'b0);
    repeat (20) begin
      len++;
      @(negedge clk_i);
    end
    start_i = 1'b1;
    cal_mode_i = 1'b1;
    len++;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(len);
    check(len == RUN_LEN, "R11", "length with restart attempt", len, RUN_LEN);
    check(pass_o && !fail_o, "R11", "status with restart attempt", {pass_o, fail_o}, 2);
    check(opnd_err == 0, "R11", "sequence undisturbed", opnd_err, 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
    report();
    $finish;
  end

  initial begin
    m_gen = G_SEED; m_sig = '0; m_ref = '0; m_op = 0; m_pat = 0;
    opnd_err = 0; fault_sel = 0; craft_pat = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_no_ref();
    t_calibrate();
    t_test_good("R7");
    t_test_fault();
    t_test_good("R6");
    t_premature();
    t_test_good("R6");
    t_busy_start();
    report();
    $finish;
  end
endmodule